// File: doc/BRIEF.md
# Spatial Array Input Port Scoreboard

This block sits between a processor pipeline and a spatial compute array. It accepts two kinds of issue: a register send, which already carries its value, and a memory load, which only reserves room for a value that the cache returns later. Each issue names a destination switch and a port on that switch. The pair selects one of the array's input ports. Every array input port has its own short in-order queue. A load takes its queue slot when it issues and marks it busy. The cache response fills that slot later. Values leave each queue strictly in issue order, so a load that completes early cannot pass an older entry on the same port.

When a load is accepted, the block returns a tag. The tag names the port and the slot the load reserved, and the cache response quotes it back. A response aimed at a slot that is not waiting for data is reported as an error and changes nothing. A squash turns every held entry, busy or ready, into an entry that the array may consume but that carries an invalid mark. The array can then drain the aborted invocation, and its results are thrown away downstream.

A small invocation controller counts the invocations in flight and caps them at a parameter, eight by default. It also holds off a reconfiguration until that count reaches zero.

Top module: `isb_input_scoreboard`

## Requirements
- R1: An issue to switch s and port p enters queue q = s*PORTS_PER_SW + p. Its value appears only on array output q.
- R2: A send (iss_kind_i = 0) is ready on accept. It is presented at the head of its queue from the next cycle when the queue was empty.
- R3: A load (iss_kind_i = 1) reserves the tail slot as busy. In the accept cycle, iss_tag_o = {q, slot}, the slot in the low $clog2(DEPTH) bits. After reset each queue hands out slots 0,1,2,... and wraps at DEPTH. A busy head keeps arr_valid_o[q] low.
- R4: A fill whose tag names a busy slot stores fill_data_i and makes the slot ready. Per port, values leave in issue order whatever the fill order. A head that is presented but not taken holds its value.
- R5: iss_ready_o is low when the addressed queue holds DEPTH entries. Queues on other ports are unaffected.
- R6: A fill to a slot that is not busy drives fill_err_o high in that cycle and leaves the slot's state and data unchanged.
- R7: In a cycle with squash_i high, iss_ready_o is low and fills are ignored with no error. From the next cycle every remaining entry is presented with arr_inval_o high.
- R8: commit_ready_o is low while MAX_INFL invocations are in flight. A done_i retires one invocation.
- R9: cfg_go_o is high only while cfg_req_i is high and no invocation is in flight. While cfg_req_i is high, commit_ready_o is low.
- R10: An array pop and an issue or fill on the same port in the same cycle both take effect.
- R11: After reset all queues are empty, all arr_valid_o bits are low, iss_ready_o and commit_ready_o are high, and fill_err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Issue request |
| iss_kind_i | input | 1 | 0 send, 1 load |
| iss_sw_i | input | SW_W | Destination switch |
| iss_pt_i | input | PT_W | Destination port on the switch |
| iss_data_i | input | DATA_W | Send value |
| iss_ready_o | output | 1 | Issue can be accepted |
| iss_tag_o | output | TAG_W | Port and slot reserved by a load |
| fill_valid_i | input | 1 | Cache response |
| fill_tag_i | input | TAG_W | Tag of the response |
| fill_data_i | input | DATA_W | Response data |
| fill_err_o | output | 1 | Response targets a non-busy slot |
| squash_i | input | 1 | Abort pending inputs |
| arr_valid_o | output | NQ | Head ready per array port |
| arr_data_o | output | NQ*DATA_W | Head value per array port |
| arr_inval_o | output | NQ | Head marked invalid by squash |
| arr_ready_i | input | NQ | Array takes the head |
| commit_i | input | 1 | Start an invocation |
| commit_ready_o | output | 1 | Commit can be accepted |
| done_i | input | 1 | One invocation completed |
| cfg_req_i | input | 1 | Reconfiguration requested |
| cfg_go_o | output | 1 | Reconfiguration may proceed |

## Verification
The risky overlap is a head pop on a port that also sees an allocation or a fill in the same cycle. The bench provokes it by holding two ready entries on one port and raising arr_ready_i together with a new send. On another port it pops a ready head while the busy entry behind it is filled. In both cases it then drains the port and checks that no entry was lost, duplicated or reordered. The second overlap is a squash that meets a fill. That fill must raise no error, and the entry it targets must still come out with the invalid mark.

// File: rtl/isb_pkg.sv
package isb_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_BUSY  = 2'd1,
    SLOT_READY = 2'd2
  } slot_state_e;
endpackage

// File: rtl/isb_port_queue.sv
module isb_port_queue
  import isb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_i,
  input  logic                      alloc_load_i,
  input  logic [DATA_W-1:0]         alloc_data_i,
  output logic                      full_o,
  output logic [$clog2(DEPTH)-1:0]  tail_o,
  input  logic                      fill_i,
  input  logic [$clog2(DEPTH)-1:0]  fill_slot_i,
  input  logic [DATA_W-1:0]         fill_data_i,
  output logic                      fill_err_o,
  input  logic                      squash_i,
  output logic                      out_valid_o,
  output logic [DATA_W-1:0]         out_data_o,
  output logic                      out_inval_o,
  input  logic                      out_ready_i
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CNT_W  = SLOT_W + 1;

  slot_state_e             st_q   [DEPTH];
  logic [DATA_W-1:0]       data_q [DEPTH];
  logic [DEPTH-1:0]        inv_q;
  logic [SLOT_W-1:0]       head_q, tail_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    pop, do_alloc, do_fill;

  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign tail_o      = tail_q;
  assign out_valid_o = (st_q[head_q] == SLOT_READY);
  assign out_data_o  = data_q[head_q];
  assign out_inval_o = inv_q[head_q];
  assign fill_err_o  = fill_i && (st_q[fill_slot_i] != SLOT_BUSY);

  assign pop      = out_valid_o && out_ready_i;
  assign do_alloc = alloc_i && !full_o && !squash_i;
  assign do_fill  = fill_i && !fill_err_o && !squash_i;

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= SLOT_EMPTY;
        data_q[i] <= '0;
      end
      inv_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop && head_q == SLOT_W'(i)) begin
          st_q[i]  <= SLOT_EMPTY;
          inv_q[i] <= 1'b0;
        end else if (squash_i && st_q[i] != SLOT_EMPTY) begin
          st_q[i]  <= SLOT_READY;
          inv_q[i] <= 1'b1;
        end else if (do_alloc && tail_q == SLOT_W'(i)) begin
          st_q[i]   <= alloc_load_i ? SLOT_BUSY : SLOT_READY;
          data_q[i] <= alloc_data_i;
          inv_q[i]  <= 1'b0;
        end else if (do_fill && fill_slot_i == SLOT_W'(i)) begin
          st_q[i]   <= SLOT_READY;
          data_q[i] <= fill_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop)      head_q <= nxt(head_q);
      if (do_alloc) tail_q <= nxt(tail_q);
      cnt_q <= cnt_q + CNT_W'(do_alloc) - CNT_W'(pop);
    end
  end

  // R5: the issue side never offers into a full queue
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);

  // R4: an untaken head keeps its value
  a_r4_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !squash_i) |=> (out_valid_o && $stable(out_data_o)));

  // R7: after a squash only marked entries remain
  a_r7_squash_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> ((cnt_q == '0) || (out_valid_o && out_inval_o)));
endmodule

// File: rtl/isb_invoc_ctl.sv
module isb_invoc_ctl #(
  parameter int MAX_INFL = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  output logic commit_ready_o,
  input  logic done_i,
  input  logic cfg_req_i,
  output logic cfg_go_o
);
  localparam int CNT_W = $clog2(MAX_INFL + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             acc, dec;

  assign commit_ready_o = (cnt_q < CNT_W'(MAX_INFL)) && !cfg_req_i;
  assign cfg_go_o       = cfg_req_i && (cnt_q == '0);
  assign acc            = commit_i && commit_ready_o;
  assign dec            = done_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(acc) - CNT_W'(dec);
  end

  // R8: each accepted commit without a retire adds one
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && commit_ready_o && !done_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R9: a pending reconfiguration never lets the count grow
  a_r9_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/isb_input_scoreboard.sv
module isb_input_scoreboard #(
  parameter int NUM_SW       = 2,
  parameter int PORTS_PER_SW = 2,
  parameter int DEPTH        = 4,
  parameter int DATA_W       = 16,
  parameter int MAX_INFL     = 8,
  localparam int NQ     = NUM_SW * PORTS_PER_SW,
  localparam int SW_W   = (NUM_SW > 1) ? $clog2(NUM_SW) : 1,
  localparam int PT_W   = (PORTS_PER_SW > 1) ? $clog2(PORTS_PER_SW) : 1,
  localparam int PORT_W = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int TAG_W  = PORT_W + SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 iss_valid_i,
  input  logic                 iss_kind_i,
  input  logic [SW_W-1:0]      iss_sw_i,
  input  logic [PT_W-1:0]      iss_pt_i,
  input  logic [DATA_W-1:0]    iss_data_i,
  output logic                 iss_ready_o,
  output logic [TAG_W-1:0]     iss_tag_o,
  input  logic                 fill_valid_i,
  input  logic [TAG_W-1:0]     fill_tag_i,
  input  logic [DATA_W-1:0]    fill_data_i,
  output logic                 fill_err_o,
  input  logic                 squash_i,
  output logic [NQ-1:0]        arr_valid_o,
  output logic [NQ*DATA_W-1:0] arr_data_o,
  output logic [NQ-1:0]        arr_inval_o,
  input  logic [NQ-1:0]        arr_ready_i,
  input  logic                 commit_i,
  output logic                 commit_ready_o,
  input  logic                 done_i,
  input  logic                 cfg_req_i,
  output logic                 cfg_go_o
);
  logic [PORT_W-1:0] dst, fill_port;
  logic [SLOT_W-1:0] fill_slot;
  logic [NQ-1:0]     full_vec, err_vec;
  logic [SLOT_W-1:0] tail_vec [NQ];
  logic              iss_acc;

  assign dst         = PORT_W'(iss_sw_i) * PORT_W'(PORTS_PER_SW) + PORT_W'(iss_pt_i);
  assign iss_ready_o = !squash_i && !full_vec[dst];
  assign iss_acc     = iss_valid_i && iss_ready_o;
  assign iss_tag_o   = {dst, tail_vec[dst]};
  assign fill_port   = fill_tag_i[TAG_W-1 -: PORT_W];
  assign fill_slot   = fill_tag_i[SLOT_W-1:0];
  assign fill_err_o  = |err_vec;

  for (genvar q = 0; q < NQ; q++) begin : g_port
    isb_port_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (iss_acc && dst == PORT_W'(q)),
      .alloc_load_i (iss_kind_i),
      .alloc_data_i (iss_data_i),
      .full_o       (full_vec[q]),
      .tail_o       (tail_vec[q]),
      .fill_i       (fill_valid_i && !squash_i && fill_port == PORT_W'(q)),
      .fill_slot_i  (fill_slot),
      .fill_data_i  (fill_data_i),
      .fill_err_o   (err_vec[q]),
      .squash_i     (squash_i),
      .out_valid_o  (arr_valid_o[q]),
      .out_data_o   (arr_data_o[q*DATA_W +: DATA_W]),
      .out_inval_o  (arr_inval_o[q]),
      .out_ready_i  (arr_ready_i[q])
    );
  end

  isb_invoc_ctl #(.MAX_INFL(MAX_INFL)) u_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .commit_i       (commit_i),
    .commit_ready_o (commit_ready_o),
    .done_i         (done_i),
    .cfg_req_i      (cfg_req_i),
    .cfg_go_o       (cfg_go_o)
  );

  // R6: a squash cycle never reports a fill error
  a_r6_no_err_in_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |-> !fill_err_o);
endmodule

// File: tb/isb_input_scoreboard_bench.sv
module isb_input_scoreboard_bench;
  localparam int NQ = 4, DW = 16, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic iss_valid = 0, iss_kind = 0;
  logic [0:0] iss_sw = 0, iss_pt = 0;
  logic [DW-1:0] iss_data = 0;
  logic iss_ready;
  logic [3:0] iss_tag;
  logic fill_valid = 0;
  logic [3:0] fill_tag = 0;
  logic [DW-1:0] fill_data = 0;
  logic fill_err, squash = 0;
  logic [NQ-1:0] arr_valid, arr_inval, arr_ready = 0;
  logic [NQ*DW-1:0] arr_data;
  logic commit = 0, commit_ready, done = 0, cfg_req = 0, cfg_go;

  isb_input_scoreboard u_isb_input_scoreboard (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_kind_i(iss_kind), .iss_sw_i(iss_sw), .iss_pt_i(iss_pt),
    .iss_data_i(iss_data), .iss_ready_o(iss_ready), .iss_tag_o(iss_tag),
    .fill_valid_i(fill_valid), .fill_tag_i(fill_tag), .fill_data_i(fill_data), .fill_err_o(fill_err),
    .squash_i(squash),
    .arr_valid_o(arr_valid), .arr_data_o(arr_data), .arr_inval_o(arr_inval), .arr_ready_i(arr_ready),
    .commit_i(commit), .commit_ready_o(commit_ready), .done_i(done),
    .cfg_req_i(cfg_req), .cfg_go_o(cfg_go)
  );

  int total = 0, bad = 0;
  int btail [NQ];
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_dst(input int q);
    iss_sw = 1'(q / 2);
    iss_pt = 1'(q % 2);
  endtask

  task automatic send(input int q, input logic [DW-1:0] d);
    @(negedge clk);
    set_dst(q); iss_kind = 0; iss_data = d; iss_valid = 1;
    @(posedge clk); #1 iss_valid = 0;
    btail[q] = (btail[q] + 1) % DEPTH;
  endtask

  task automatic load(input int q, output logic [3:0] tag);
    @(negedge clk);
    set_dst(q); iss_kind = 1; iss_data = 16'hdead; iss_valid = 1;
    #1 chk("R3 tag", 32'(iss_tag), 32'(q * DEPTH + btail[q]));
    tag = iss_tag;
    @(posedge clk); #1 iss_valid = 0;
    btail[q] = (btail[q] + 1) % DEPTH;
  endtask

  task automatic fill(input logic [3:0] tag, input logic [DW-1:0] d, input logic exp_err);
    @(negedge clk);
    fill_tag = tag; fill_data = d; fill_valid = 1;
    #1 chk("R6 fill_err", 32'(fill_err), 32'(exp_err));
    @(posedge clk); #1 fill_valid = 0;
  endtask

  task automatic pop(input int q, input logic [DW-1:0] d, input logic inv, input string req);
    @(negedge clk);
    chk({req, " valid"}, 32'(arr_valid[q]), 1);
    chk({req, " data"}, 32'(arr_data[q*DW +: DW]), 32'(d));
    chk({req, " inval"}, 32'(arr_inval[q]), 32'(inv));
    arr_ready[q] = 1;
    @(posedge clk); #1 arr_ready[q] = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] t0, t1, t2;
    for (int q = 0; q < NQ; q++) btail[q] = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 arr_valid", 32'(arr_valid), 0);
    chk("R11 iss_ready", 32'(iss_ready), 1);
    chk("R11 commit_ready", 32'(commit_ready), 1);
    chk("R11 fill_err", 32'(fill_err), 0);

    // R1 R2 R5: fill each port, check stall, drain in order
    for (int q = 0; q < NQ; q++) begin
      for (int k = 0; k < DEPTH; k++) send(q, DW'(q * 256 + k * 7 + 3));
      @(negedge clk);
      set_dst(q);
      #1 chk("R5 full stall", 32'(iss_ready), 0);
      set_dst((q + 1) % NQ);
      #1 chk("R5 other port free", 32'(iss_ready), 1);
      chk("R1 only own port", 32'(arr_valid), 32'(1 << q));
      for (int k = 0; k < DEPTH; k++) pop(q, DW'(q * 256 + k * 7 + 3), 0, "R2 R1 order");
      @(negedge clk);
      chk("R1 drained", 32'(arr_valid[q]), 0);
    end

    // R3 R4: loads filled out of order with a send behind them
    for (int q = 0; q < NQ; q++) begin
      load(q, t0);
      load(q, t1);
      send(q, DW'(16'h5000 + q));
      @(negedge clk);
      chk("R3 busy head blocks", 32'(arr_valid[q]), 0);
      fill(t1, DW'(16'h2100 + q), 0);
      @(negedge clk);
      chk("R4 later fill waits", 32'(arr_valid[q]), 0);
      fill(t0, DW'(16'h2000 + q), 0);
      pop(q, DW'(16'h2000 + q), 0, "R4 first");
      pop(q, DW'(16'h2100 + q), 0, "R4 second");
      pop(q, DW'(16'h5000 + q), 0, "R4 send last");
      // R6: stale tag now empty
      fill(t0, 16'hbeef, 1);
      @(negedge clk);
      chk("R6 no change empty", 32'(arr_valid[q]), 0);
    end

    // R6: fill to a ready slot leaves data untouched
    send(0, 16'h1234);
    fill(4'(0 * DEPTH + (btail[0] + DEPTH - 1) % DEPTH), 16'hffff, 1);
    pop(0, 16'h1234, 0, "R6 ready slot kept");

    // R7: squash with a fill in the same cycle
    load(1, t0);
    send(1, 16'h7777);
    load(2, t2);
    @(negedge clk);
    squash = 1; fill_tag = t2; fill_data = 16'h9999; fill_valid = 1;
    set_dst(3);
    #1 chk("R7 issue stalled", 32'(iss_ready), 0);
    chk("R7 fill ignored no err", 32'(fill_err), 0);
    @(posedge clk); #1 squash = 0; fill_valid = 0;
    @(negedge clk);
    chk("R7 port1 inval", 32'(arr_inval[1]), 1);
    chk("R7 port2 inval", 32'(arr_inval[2]), 1);
    arr_ready[1] = 1;
    @(posedge clk); #1 arr_ready[1] = 0;
    pop(1, 16'h7777, 1, "R7 send marked");
    @(negedge clk);
    chk("R7 port2 still inval", 32'(arr_valid[2] & arr_inval[2]), 1);
    arr_ready[2] = 1;
    @(posedge clk); #1 arr_ready[2] = 0;
    fill(t0, 16'h0101, 1);

    // R10: pop and send on one port in one cycle
    send(3, 16'h00a1);
    send(3, 16'h00b2);
    @(negedge clk);
    set_dst(3); iss_kind = 0; iss_data = 16'h00c3; iss_valid = 1; arr_ready[3] = 1;
    chk("R10 head before", 32'(arr_data[3*DW +: DW]), 32'h00a1);
    @(posedge clk); #1 iss_valid = 0; arr_ready[3] = 0;
    btail[3] = (btail[3] + 1) % DEPTH;
    pop(3, 16'h00b2, 0, "R10 pop+send second");
    pop(3, 16'h00c3, 0, "R10 pop+send third");
    @(negedge clk);
    chk("R10 port3 empty", 32'(arr_valid[3]), 0);

    // R10: pop and fill on one port in one cycle
    send(0, 16'h0d0d);
    load(0, t1);
    @(negedge clk);
    fill_tag = t1; fill_data = 16'h0e0e; fill_valid = 1; arr_ready[0] = 1;
    #1 chk("R10 fill ok", 32'(fill_err), 0);
    @(posedge clk); #1 fill_valid = 0; arr_ready[0] = 0;
    pop(0, 16'h0e0e, 0, "R10 pop+fill");

    // R8 R9: invocation limit and reconfiguration gating
    @(negedge clk);
    cfg_req = 1;
    #1 chk("R9 go when idle", 32'(cfg_go), 1);
    chk("R9 commit held by cfg", 32'(commit_ready), 0);
    cfg_req = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #1 chk("R8 commit open", 32'(commit_ready), 1);
      commit = 1;
      @(posedge clk); #1 commit = 0;
    end
    @(negedge clk);
    chk("R8 cap reached", 32'(commit_ready), 0);
    cfg_req = 1;
    #1 chk("R9 go blocked", 32'(cfg_go), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      #1 chk("R9 wait drain", 32'(cfg_go), 0);
      done = 1;
      @(posedge clk); #1 done = 0;
    end
    @(negedge clk);
    #1 chk("R9 go after drain", 32'(cfg_go), 1);
    cfg_req = 0;
    #1 chk("R8 commit reopened", 32'(commit_ready), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule